// File: doc/BRIEF.md
# Asynchronous Memory Strobe Timing Engine

This block produces the chip-select, read-strobe and write-strobe waveforms for one chip select of an asynchronous external memory bus, as used for NOR or NAND flash and similar static parts. A requester presents a read or a write with address and write data. Once the engine is idle it takes the request and runs one access. That access lasts a programmed number of system clocks. Inside it, every strobe goes low and returns high at clock counts that are programmed separately for each strobe.

Read and write accesses each have their own timing set. In that set, the chip select and the read or write strobe each have a setup count, which is the first access cycle in which the signal is low, and a pulse count, which is the number of cycles it stays low. A total length closes the access. Any strobe window that would run past the total length is cut off at the end of the access, and a configuration error flag reports the overrun. Read data is captured on the clock edge at which the selected controlling signal returns high. A programmable number of data-float cycles after each read keeps the bus released before the next access. A width select chooses between an 8-bit and a 16-bit data path.

Top module: `static_mem_timer`

## Requirements
- R1: After reset, cs_n, re_n and we_n are high, ack and mem_doe are low and req_ready is high.
- R2: The access counter is 0 in the first cycle after a request is taken. It advances by one each cycle. A strobe is low in exactly the counter values k with setup <= k < setup+pulse. Reads use rd_cs_* for cs_n and rd_re_* for re_n. Writes use wr_cs_* for cs_n and wr_we_* for we_n.
- R3: An access lasts total cycles: rd_total for reads, wr_total for writes, and a value of 0 counts as 1. A strobe window end is clamped to total, so every strobe is high again once the access ends. If setup >= total, the strobe never goes low.
- R4: ack is high for exactly one cycle: the cycle after the last access cycle.
- R5: On a read, rdata takes mem_din from the clock edge at which the controlling signal returns high (clamped end minus one is the last low counter value). With rd_mode=1 the controlling signal is re_n; with rd_mode=0 it is cs_n. If that window is empty, rdata keeps its old value. rdata never changes outside a read access.
- R6: After a read, req_ready stays low for float_cycles cycles, the first of which is the ack cycle. After a write, or when float_cycles is 0, req_ready is high in the ack cycle.
- R7: With bus16=0, bits 15:8 of rdata and of mem_dout are zero. With bus16=1, all 16 bits pass through.
- R8: cfg_err is high whenever any of the four setup+pulse sums exceeds its own effective total, and low otherwise.
- R9: During a write access mem_doe is high and re_n stays high. During a read access mem_doe is low and we_n stays high. mem_addr holds the request address for the whole access.
- R10: While req_ready is low, req_valid is ignored. The pending request starts only after req_ready returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_cs_setup | input | CNT_W | Read: first cycle of cs_n low |
| rd_cs_pulse | input | CNT_W | Read: cs_n low length |
| rd_re_setup | input | CNT_W | Read: first cycle of re_n low |
| rd_re_pulse | input | CNT_W | Read: re_n low length |
| rd_total | input | CNT_W | Read access length |
| wr_cs_setup | input | CNT_W | Write: first cycle of cs_n low |
| wr_cs_pulse | input | CNT_W | Write: cs_n low length |
| wr_we_setup | input | CNT_W | Write: first cycle of we_n low |
| wr_we_pulse | input | CNT_W | Write: we_n low length |
| wr_total | input | CNT_W | Write access length |
| float_cycles | input | FLT_W | Idle cycles after a read |
| rd_mode | input | 1 | 1: read data captured at re_n rise, 0: at cs_n rise |
| bus16 | input | 1 | 1: 16-bit data path, 0: 8-bit |
| cfg_err | output | 1 | A strobe window overruns its total |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Engine idle, request taken at this edge |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | Address to memory |
| mem_dout | output | DATA_W | Write data to memory |
| mem_doe | output | 1 | Write data drive enable |
| mem_din | input | DATA_W | Read data from memory |
| cs_n | output | 1 | Chip select, active low |
| re_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |

## Verification
The bench builds the block with CNT_W=4 and FLT_W=3. With these widths, a setup plus pulse sum can pass the largest total of 15, so clamping and the error flag show up often in random configurations. A float count of up to 7 covers long turnaround. Random setups, pulses, totals and modes run beside directed cases: the 2/7/13 timing, zero-length pulses, setup at or past the total, and a total of one cycle. Read data changes every cycle, so capture on the wrong edge gives a wrong value.

// File: rtl/static_mem_timer.sv
module static_mem_timer #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6,
  parameter int FLT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  rd_cs_setup,
  input  logic [CNT_W-1:0]  rd_cs_pulse,
  input  logic [CNT_W-1:0]  rd_re_setup,
  input  logic [CNT_W-1:0]  rd_re_pulse,
  input  logic [CNT_W-1:0]  rd_total,
  input  logic [CNT_W-1:0]  wr_cs_setup,
  input  logic [CNT_W-1:0]  wr_cs_pulse,
  input  logic [CNT_W-1:0]  wr_we_setup,
  input  logic [CNT_W-1:0]  wr_we_pulse,
  input  logic [CNT_W-1:0]  wr_total,
  input  logic [FLT_W-1:0]  float_cycles,
  input  logic              rd_mode,
  input  logic              bus16,
  output logic              cfg_err,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_doe,
  input  logic [DATA_W-1:0] mem_din,
  output logic              cs_n,
  output logic              re_n,
  output logic              we_n
);
  localparam int SUM_W = CNT_W + 1;
  localparam int HI_W  = DATA_W - 8;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_FLT} state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic [FLT_W-1:0]   fcnt;
  logic               is_wr;
  logic [DATA_W-1:0]  wdata_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               ack_q;

  function automatic logic [SUM_W-1:0] eff_total(input logic [CNT_W-1:0] t);
    return (t == '0) ? SUM_W'(1) : SUM_W'(t);
  endfunction

  function automatic logic [SUM_W-1:0] win_end(input logic [CNT_W-1:0] s,
      input logic [CNT_W-1:0] p, input logic [SUM_W-1:0] t);
    logic [SUM_W-1:0] sum;
    sum = SUM_W'(s) + SUM_W'(p);
    return (sum > t) ? t : sum;
  endfunction

  function automatic logic in_win(input logic [CNT_W-1:0] k, input logic [CNT_W-1:0] s,
      input logic [CNT_W-1:0] p, input logic [SUM_W-1:0] t);
    return (k >= s) && (SUM_W'(k) < win_end(s, p, t));
  endfunction

  logic [SUM_W-1:0] rd_tot, wr_tot, cur_tot;
  assign rd_tot  = eff_total(rd_total);
  assign wr_tot  = eff_total(wr_total);
  assign cur_tot = is_wr ? wr_tot : rd_tot;

  logic acc, last;
  assign acc  = (state == S_ACC);
  assign last = acc && (SUM_W'(cnt) == cur_tot - SUM_W'(1));

  logic cs_on, re_on, we_on;
  assign cs_on = acc && (is_wr ? in_win(cnt, wr_cs_setup, wr_cs_pulse, wr_tot)
                               : in_win(cnt, rd_cs_setup, rd_cs_pulse, rd_tot));
  assign re_on = acc && !is_wr && in_win(cnt, rd_re_setup, rd_re_pulse, rd_tot);
  assign we_on = acc && is_wr && in_win(cnt, wr_we_setup, wr_we_pulse, wr_tot);

  logic [CNT_W-1:0] lat_s, lat_p;
  logic [SUM_W-1:0] lat_end;
  logic             lat_hit;
  assign lat_s   = rd_mode ? rd_re_setup : rd_cs_setup;
  assign lat_p   = rd_mode ? rd_re_pulse : rd_cs_pulse;
  assign lat_end = win_end(lat_s, lat_p, rd_tot);
  assign lat_hit = acc && !is_wr && (lat_end > SUM_W'(lat_s)) &&
                   (SUM_W'(cnt) == lat_end - SUM_W'(1));

  assign cfg_err = (SUM_W'(rd_cs_setup) + SUM_W'(rd_cs_pulse) > rd_tot) ||
                   (SUM_W'(rd_re_setup) + SUM_W'(rd_re_pulse) > rd_tot) ||
                   (SUM_W'(wr_cs_setup) + SUM_W'(wr_cs_pulse) > wr_tot) ||
                   (SUM_W'(wr_we_setup) + SUM_W'(wr_we_pulse) > wr_tot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      fcnt     <= '0;
      is_wr    <= 1'b0;
      mem_addr <= '0;
      wdata_q  <= '0;
      ack_q    <= 1'b0;
    end else begin
      ack_q <= last;
      case (state)
        S_IDLE: if (req_valid) begin
          state    <= S_ACC;
          cnt      <= '0;
          is_wr    <= req_write;
          mem_addr <= req_addr;
          wdata_q  <= req_wdata;
        end
        S_ACC: if (last) begin
          if (!is_wr && float_cycles != '0) begin
            state <= S_FLT;
            fcnt  <= float_cycles;
          end else begin
            state <= S_IDLE;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: if (fcnt <= FLT_W'(1)) state <= S_IDLE;
                 else fcnt <= fcnt - 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (lat_hit) rdata_q <= bus16 ? mem_din : {{HI_W{1'b0}}, mem_din[7:0]};
  end

  assign req_ready = (state == S_IDLE);
  assign ack       = ack_q;
  assign rdata     = rdata_q;
  assign mem_doe   = acc && is_wr;
  assign mem_dout  = bus16 ? wdata_q : {{HI_W{1'b0}}, wdata_q[7:0]};
  assign cs_n      = !cs_on;
  assign re_n      = !re_on;
  assign we_n      = !we_on;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && re_n && we_n && !mem_doe));
  p_ack_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  p_ack_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (cs_n && re_n && we_n));
  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc || is_wr) |=> $stable(rdata));
  p_wr_no_re_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_doe |-> re_n);
  p_rd_no_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> (we_n && !mem_doe));
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !last) |=> $stable(mem_addr));
  p_byte_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus16 && $stable(bus16)) |=> (rdata[DATA_W-1:8] == '0 || !$past(lat_hit)));
endmodule

// File: tb/static_mem_timer_tb.sv
module static_mem_timer_tb_top;
  localparam int AW = 24, DW = 16, CW = 4, FW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [CW-1:0] rcs_s, rcs_p, rre_s, rre_p, rtot, wcs_s, wcs_p, wwe_s, wwe_p, wtot;
  logic [FW-1:0] flt;
  logic rd_mode, bus16, cfg_err, req_valid, req_write, req_ready, ack, mem_doe, cs_n, re_n, we_n;
  logic [AW-1:0] req_addr, mem_addr;
  logic [DW-1:0] req_wdata, rdata, mem_dout, mem_din;

  int checks = 0, errors = 0;
  logic [DW-1:0] exp_rdata = '0;

  static_mem_timer #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .FLT_W(FW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_cs_setup(rcs_s), .rd_cs_pulse(rcs_p), .rd_re_setup(rre_s), .rd_re_pulse(rre_p),
    .rd_total(rtot), .wr_cs_setup(wcs_s), .wr_cs_pulse(wcs_p), .wr_we_setup(wwe_s),
    .wr_we_pulse(wwe_p), .wr_total(wtot), .float_cycles(flt), .rd_mode(rd_mode),
    .bus16(bus16), .cfg_err(cfg_err), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready), .ack(ack),
    .rdata(rdata), .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe),
    .mem_din(mem_din), .cs_n(cs_n), .re_n(re_n), .we_n(we_n));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int tot_of(input int t);
    return (t == 0) ? 1 : t;
  endfunction
  function automatic int end_of(input int s, input int p, input int t);
    return (s + p > t) ? t : s + p;
  endfunction
  function automatic bit on_at(input int k, input int s, input int p, input int t);
    return (k >= s) && (k < end_of(s, p, t));
  endfunction
  function automatic bit err_exp();
    return (rcs_s + rcs_p > tot_of(rtot)) || (rre_s + rre_p > tot_of(rtot)) ||
           (wcs_s + wcs_p > tot_of(wtot)) || (wwe_s + wwe_p > tot_of(wtot));
  endfunction
  function automatic logic [DW-1:0] lane(input logic [DW-1:0] v);
    return bus16 ? v : {8'h00, v[7:0]};
  endfunction

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [DW-1:0] pat);
    int t, ls, lp, le;
    @(negedge clk);
    chk(cfg_err == err_exp(), "R8 cfg_err", cfg_err, err_exp());
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    t  = wr ? tot_of(wtot) : tot_of(rtot);
    ls = rd_mode ? rre_s : rcs_s;
    lp = rd_mode ? rre_p : rcs_p;
    le = end_of(ls, lp, t);
    for (int k = 0; k < t; k++) begin
      mem_din = pat + DW'(k);
      if (wr) begin
        chk(cs_n == !on_at(k, wcs_s, wcs_p, t), "R2/R3 write cs_n", cs_n, !on_at(k, wcs_s, wcs_p, t));
        chk(we_n == !on_at(k, wwe_s, wwe_p, t), "R2/R3 we_n", we_n, !on_at(k, wwe_s, wwe_p, t));
        chk(re_n && mem_doe, "R9 write re_n/doe", {re_n, mem_doe}, 2'b11);
        chk(mem_dout == lane(d), "R7 mem_dout", mem_dout, lane(d));
      end else begin
        chk(cs_n == !on_at(k, rcs_s, rcs_p, t), "R2/R3 read cs_n", cs_n, !on_at(k, rcs_s, rcs_p, t));
        chk(re_n == !on_at(k, rre_s, rre_p, t), "R2/R3 re_n", re_n, !on_at(k, rre_s, rre_p, t));
        chk(we_n && !mem_doe, "R9 read we_n/doe", {we_n, mem_doe}, 2'b10);
        if (le > ls && k == le - 1) exp_rdata = lane(pat + DW'(k));
      end
      chk(mem_addr == a, "R9 mem_addr", mem_addr, a);
      chk(!ack && !req_ready, "R4 no early ack", {ack, req_ready}, 0);
      @(negedge clk);
    end
    chk(ack == 1'b1, "R4 ack", ack, 1);
    chk(cs_n && re_n && we_n, "R3 strobes released", {cs_n, re_n, we_n}, 3'b111);
    chk(rdata == exp_rdata, "R5 rdata", rdata, exp_rdata);
    if (!wr && flt != 0) begin
      for (int f = 0; f < flt; f++) begin
        req_valid = 1'b1; req_write = 1'b1;
        chk(!req_ready, "R6 float busy", req_ready, 0);
        chk(cs_n && we_n, "R10 request ignored", {cs_n, we_n}, 2'b11);
        @(negedge clk);
        req_valid = 1'b0;
        if (f == 0) chk(!ack, "R4 ack single", ack, 0);
      end
    end
    chk(req_ready, "R6 ready after access", req_ready, 1);
  endtask

  task automatic set_all(input int s, input int p, input int t);
    rcs_s = CW'(s); rcs_p = CW'(p); rre_s = CW'(s); rre_p = CW'(p); rtot = CW'(t);
    wcs_s = CW'(s); wcs_p = CW'(p); wwe_s = CW'(s); wwe_p = CW'(p); wtot = CW'(t);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    set_all(2, 7, 13); flt = 3'd1; rd_mode = 1'b1; bus16 = 1'b1;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; mem_din = '0;
    repeat (3) @(negedge clk);
    chk(cs_n && re_n && we_n && !ack && !mem_doe && req_ready, "R1 reset state",
        {cs_n, re_n, we_n, ack, mem_doe, req_ready}, 6'b111001);
    rst_n = 1'b1;
    access(1'b1, 24'h00_1234, 16'hA55A, 16'h0);
    access(1'b0, 24'h00_0040, 16'h0, 16'h3C00);
    bus16 = 1'b0;
    access(1'b0, 24'h00_0041, 16'h0, 16'hBE10);
    access(1'b1, 24'h00_0042, 16'hC3F1, 16'h0);
    bus16 = 1'b1;
    rd_mode = 1'b0; rre_s = 4'd4; rre_p = 4'd2;
    access(1'b0, 24'h00_0100, 16'h0, 16'h7100);
    set_all(3, 0, 6); rd_mode = 1'b1;
    access(1'b0, 24'h00_0200, 16'h0, 16'h2200);
    set_all(9, 4, 7); flt = 3'd0;
    access(1'b0, 24'h00_0300, 16'h0, 16'h3300);
    access(1'b1, 24'h00_0301, 16'h1111, 16'h0);
    set_all(0, 1, 1); flt = 3'd7;
    access(1'b0, 24'h00_0400, 16'h0, 16'h4400);
    set_all(0, 15, 0);
    access(1'b1, 24'h00_0500, 16'h5555, 16'h0);
    for (int n = 0; n < 300; n++) begin
      rcs_s = CW'($urandom_range(0, 6)); rcs_p = CW'($urandom_range(0, 9));
      rre_s = CW'($urandom_range(0, 6)); rre_p = CW'($urandom_range(0, 9));
      wcs_s = CW'($urandom_range(0, 6)); wcs_p = CW'($urandom_range(0, 9));
      wwe_s = CW'($urandom_range(0, 6)); wwe_p = CW'($urandom_range(0, 9));
      rtot = CW'($urandom_range(1, 15)); wtot = CW'($urandom_range(1, 15));
      flt = FW'($urandom_range(0, 7)); rd_mode = 1'($urandom); bus16 = 1'($urandom);
      access(1'($urandom), AW'($urandom), DW'($urandom), DW'($urandom));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule